// File: doc/BRIEF.md
# External Memory Bus Cycle Sequencer

This block produces the strobe and address/data timing that an 8-bit controller core needs to reach external program and data memory. It runs on the oscillator clock. A machine cycle is twelve oscillator periods long, grouped as six states of two periods each. A free-running period counter sets the schedule. The counter is exposed as a state number and a phase bit.

On the schedule, the block pulses an address-latch strobe twice per machine cycle. When code comes from external memory, it also drops a program-read strobe low twice per machine cycle. The high address byte and the multiplexed low address/data byte are driven onto the pins with the right timing.

The core requests a data access by raising `dreq` together with the direction, the 16-bit address and the write data. The request is taken on the last period of a machine cycle. It then occupies the following two machine cycles, called A and B:
- In A, the data address is driven and latched.
- A single read or write strobe then spans the end of A and the first half of B.
- The address-latch pulse and the program-read pulses that fall in that strobe window are suppressed.
- Read data is captured as the read strobe rises.

The code-source select pin is captured only while reset is asserted.

Top module: `xbus_seq`

## Requirements
- R1: The period counter runs 0..11 and wraps to 0. It is 0 during and directly after reset. `mstate` equals the counter divided by two (0..5), and `mphase` is its lowest bit.
- R2: `addr_stb` is high exactly in periods 1, 2, 7 and 8 (one pulse every six periods), except as stated in R3.
- R3: In machine cycle B of a data access, `addr_stb` stays low in periods 1 and 2.
- R4: With external code selected, `prog_rd_n` is low in periods 3–5 and 9–11 and high otherwise, except as stated in R5.
- R5: During a data access, `prog_rd_n` stays high in periods 9–11 of cycle A and periods 3–5 of cycle B. With internal code selected, `prog_rd_n` is always high.
- R6: `dack` is high exactly when `dreq` is high in period 11 and the current cycle is not cycle A. The accepted request defines the following cycles A and B.
- R7: The access strobe (`data_rd_n` for a read, `data_wr_n` for a write; `dwe`=1 means write) is low from period 9 of A through period 5 of B. The other strobe stays high.
- R8: `addr_hi` carries the data address bits 15..8 from period 6 of A through period 5 of B. At all other times it carries `fetch_addr` bits 15..8.
- R9: `ad_o` carries the data address bits 7..0 in periods 6–8 of A, with `ad_oe`=1. During a write strobe, `ad_o` carries the write byte with `ad_oe`=1. In periods 0–2 and 6–8 outside the data window, it carries `fetch_addr` bits 7..0, with `ad_oe`=1 only when external code is selected. Everywhere else `ad_oe`=0, including the whole read strobe.
- R10: For a read, `ad_i` is captured into `drdata` at the edge that ends period 5 of B. `drvalid` is high for exactly period 6 of B.
- R11: `code_src_int` is sampled only while `rst_n` is low (1 = internal code, 0 = external code). After reset, changes on it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| code_src_int | input | 1 | Code source select, sampled in reset (1 internal) |
| fetch_addr | input | 16 | Current program fetch address from the core |
| dreq | input | 1 | Data access request |
| dwe | input | 1 | Data access direction, 1 = write |
| daddr | input | 16 | Data access address |
| dwdata | input | 8 | Data write byte |
| dack | output | 1 | Request accepted this period |
| drdata | output | 8 | Captured read byte |
| drvalid | output | 1 | Read byte valid pulse |
| addr_stb | output | 1 | Address-latch strobe, active high |
| prog_rd_n | output | 1 | Program-read strobe, active low |
| data_rd_n | output | 1 | Data read strobe, active low |
| data_wr_n | output | 1 | Data write strobe, active low |
| addr_hi | output | 8 | High address byte |
| ad_o | output | 8 | Low address/data byte out |
| ad_oe | output | 1 | Output enable for the low byte |
| ad_i | input | 8 | Low byte in (read data) |
| mstate | output | 3 | Machine state 0..5 |
| mphase | output | 1 | Phase within the state |

## Verification
The assertions assume that a request is held stable only for the period in which it is sampled. The block latches the request fields on acceptance, so nothing after that point depends on the core. The write-data check likewise relies on the latched byte, not on `dwdata` staying steady.

The stimulus redraws every input at random on each falling edge, including `code_src_int` after reset. This exercises back-to-back accesses, requests that arrive while cycle A is under way, and code-select changes that must be ignored. Both code sources are covered by separate reset phases.

// File: rtl/xbus_seq.sv
module xbus_seq (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        code_src_int,
  input  logic [15:0] fetch_addr,
  input  logic        dreq,
  input  logic        dwe,
  input  logic [15:0] daddr,
  input  logic [7:0]  dwdata,
  output logic        dack,
  output logic [7:0]  drdata,
  output logic        drvalid,
  output logic        addr_stb,
  output logic        prog_rd_n,
  output logic        data_rd_n,
  output logic        data_wr_n,
  output logic [7:0]  addr_hi,
  output logic [7:0]  ad_o,
  output logic        ad_oe,
  input  logic [7:0]  ad_i,
  output logic [2:0]  mstate,
  output logic        mphase
);
  localparam logic [3:0] LAST = 4'd11;

  logic [3:0]  cnt;
  logic        in_a, in_b, ext_mode, we_q;
  logic [15:0] daddr_q;
  logic [7:0]  wd_q;
  logic        last, lo_adr, hi_adr, strobe, dwin, dadr_ph, adr_ph;

  assign last    = (cnt == LAST);
  assign lo_adr  = (cnt <= 4'd2);
  assign hi_adr  = (cnt >= 4'd6) && (cnt <= 4'd8);
  assign strobe  = (in_a && cnt >= 4'd9) || (in_b && cnt <= 4'd5);
  assign dwin    = (in_a && cnt >= 4'd6) || (in_b && cnt <= 4'd5);
  assign dadr_ph = in_a && hi_adr;
  assign adr_ph  = (lo_adr && !in_b) || (hi_adr && !in_a);

  assign dack      = dreq && last && !in_a;
  assign mstate    = cnt[3:1];
  assign mphase    = cnt[0];
  assign addr_stb  = ((cnt == 4'd1 || cnt == 4'd2) && !in_b) || cnt == 4'd7 || cnt == 4'd8;
  assign prog_rd_n = !(ext_mode && ((cnt >= 4'd3 && cnt <= 4'd5 && !in_b) ||
                                    (cnt >= 4'd9 && !in_a)));
  assign data_rd_n = !(strobe && !we_q);
  assign data_wr_n = !(strobe && we_q);
  assign addr_hi   = dwin ? daddr_q[15:8] : fetch_addr[15:8];
  assign ad_o      = dadr_ph ? daddr_q[7:0] : (strobe ? wd_q : fetch_addr[7:0]);
  assign ad_oe     = dadr_ph || (strobe && we_q) || (adr_ph && ext_mode);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      in_a     <= 1'b0;
      in_b     <= 1'b0;
      ext_mode <= !code_src_int;
      we_q     <= 1'b0;
      daddr_q  <= '0;
      wd_q     <= '0;
      drdata   <= '0;
      drvalid  <= 1'b0;
    end else begin
      cnt     <= last ? 4'd0 : cnt + 4'd1;
      drvalid <= 1'b0;
      if (last) begin
        in_b <= in_a;
        in_a <= dack;
      end
      if (dack) begin
        we_q    <= dwe;
        daddr_q <= daddr;
        wd_q    <= dwdata;
      end
      if (in_b && cnt == 4'd5 && !we_q) begin
        drdata  <= ad_i;
        drvalid <= 1'b1;
      end
    end
  end

  p_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    mstate == 3'd5 && mphase |=> mstate == 3'd0 && !mphase);
  p_stb_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(addr_stb) |-> (mstate == 3'd0 || mstate == 3'd3) && mphase);
  p_stb_vs_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !(addr_stb && (!data_rd_n || !data_wr_n)));
  p_prog_vs_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(!prog_rd_n && (!data_rd_n || !data_wr_n)));
  p_int_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_mode |-> prog_rd_n);
  p_one_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    data_rd_n || data_wr_n);
  p_rd_float_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !data_rd_n |-> !ad_oe);
  p_wr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !data_wr_n && $past(!data_wr_n) |-> $stable(ad_o) && ad_oe);
  p_rd_valid_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_rd_n) |-> drvalid);
  p_mode_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(ext_mode));
endmodule

// File: tb/xbus_seq_tb.sv
module xbus_seq_tb_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, code_src_int = 1'b1;
  logic [15:0] fetch_addr = '0, daddr = '0;
  logic dreq = 1'b0, dwe = 1'b0;
  logic [7:0] dwdata = '0, ad_i = '0;
  logic dack, drvalid, addr_stb, prog_rd_n, data_rd_n, data_wr_n, ad_oe, mphase;
  logic [7:0] drdata, addr_hi, ad_o;
  logic [2:0] mstate;

  int checks = 0, errors = 0;
  int seed = 1234;
  bit done = 0;

  int m_cnt = 0;
  bit m_a = 0, m_b = 0, m_we = 0, m_ext = 0, m_valid = 0;
  logic [15:0] m_addr = '0;
  logic [7:0]  m_wd = '0, m_rd = '0;
  int n_acc = 0, n_rd = 0;

  xbus_seq dut_i (.clk(clk), .rst_n(rst_n), .code_src_int(code_src_int),
    .fetch_addr(fetch_addr), .dreq(dreq), .dwe(dwe), .daddr(daddr), .dwdata(dwdata),
    .dack(dack), .drdata(drdata), .drvalid(drvalid), .addr_stb(addr_stb),
    .prog_rd_n(prog_rd_n), .data_rd_n(data_rd_n), .data_wr_n(data_wr_n),
    .addr_hi(addr_hi), .ad_o(ad_o), .ad_oe(ad_oe), .ad_i(ad_i),
    .mstate(mstate), .mphase(mphase));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic bit f_ack();
    return dreq && m_cnt == 11 && !m_a;
  endfunction
  function automatic bit f_stb();
    if (m_b && m_cnt <= 2) return 0;
    return m_cnt == 1 || m_cnt == 2 || m_cnt == 7 || m_cnt == 8;
  endfunction
  function automatic bit f_prog_n();
    if (!m_ext) return 1;
    if (m_cnt >= 3 && m_cnt <= 5 && !m_b) return 0;
    if (m_cnt >= 9 && !m_a) return 0;
    return 1;
  endfunction
  function automatic bit f_strobe();
    return (m_a && m_cnt >= 9) || (m_b && m_cnt <= 5);
  endfunction
  function automatic logic [7:0] f_hi();
    return ((m_a && m_cnt >= 6) || (m_b && m_cnt <= 5)) ? m_addr[15:8] : fetch_addr[15:8];
  endfunction
  function automatic bit f_oe();
    bit dadr = m_a && m_cnt >= 6 && m_cnt <= 8;
    bit fadr = (m_cnt <= 2 && !m_b) || (m_cnt >= 6 && m_cnt <= 8 && !m_a);
    return dadr || (f_stroke_w()) || (fadr && m_ext);
  endfunction
  function automatic bit f_stroke_w();
    return f_strobe() && m_we;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt <= 0; m_a <= 0; m_b <= 0; m_ext <= !code_src_int; m_valid <= 0;
    end else begin
      m_cnt <= (m_cnt == 11) ? 0 : m_cnt + 1;
      m_valid <= 0;
      if (m_cnt == 11) begin m_b <= m_a; m_a <= f_ack(); end
      if (f_ack()) begin m_we <= dwe; m_addr <= daddr; m_wd <= dwdata; end
      if (m_b && m_cnt == 5 && !m_we) begin m_rd <= ad_i; m_valid <= 1; end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s cnt=%0d act=%0h exp=%0h", req, m_cnt, act, exp);
    end
  endtask

  task automatic check_all();
    logic [7:0] exp_o;
    chk({mstate, mphase} == 4'(m_cnt), "R1 state counter", {mstate, mphase}, 16'(m_cnt));
    chk(addr_stb == f_stb(), (m_b && m_cnt <= 2) ? "R3 strobe withheld" : "R2 addr strobe",
        16'(addr_stb), 16'(f_stb()));
    chk(prog_rd_n == f_prog_n(),
        ((m_a && m_cnt >= 9) || (m_b && m_cnt >= 3 && m_cnt <= 5) || !m_ext) ?
        "R5 prog strobe dropped" : "R4 prog strobe", 16'(prog_rd_n), 16'(f_prog_n()));
    chk(dack == f_ack(), "R6 dack", 16'(dack), 16'(f_ack()));
    chk(data_rd_n == !(f_strobe() && !m_we), "R7 read strobe", 16'(data_rd_n), 16'(!(f_strobe() && !m_we)));
    chk(data_wr_n == !(f_strobe() && m_we), "R7 write strobe", 16'(data_wr_n), 16'(!(f_strobe() && m_we)));
    chk(addr_hi == f_hi(), "R8 high address", 16'(addr_hi), 16'(f_hi()));
    chk(ad_oe == f_oe(), "R9 low enable", 16'(ad_oe), 16'(f_oe()));
    if (f_oe()) begin
      exp_o = (m_a && m_cnt >= 6 && m_cnt <= 8) ? m_addr[7:0] : (f_strobe() ? m_wd : fetch_addr[7:0]);
      chk(ad_o == exp_o, "R9 low byte", 16'(ad_o), 16'(exp_o));
    end
    chk(drvalid == m_valid, "R10 read valid", 16'(drvalid), 16'(m_valid));
    if (m_valid) begin
      chk(drdata == m_rd, "R10 read data", 16'(drdata), 16'(m_rd));
      n_rd++;
    end
    if (dack) n_acc++;
  endtask

  task automatic run(input int cycles, input int req_pct, input bit vary_sel);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      check_all();
      fetch_addr = 16'($urandom);
      daddr      = 16'($urandom);
      dwdata     = 8'($urandom);
      ad_i       = 8'($urandom);
      dwe        = 1'($urandom);
      dreq       = ($urandom % 100) < req_pct;
      if (vary_sel) code_src_int = 1'($urandom);
    end
  endtask

  task automatic do_reset(input bit sel);
    @(negedge clk);
    rst_n = 1'b0; code_src_int = sel; dreq = 1'b0;
    repeat (3) @(negedge clk);
    chk(mstate == 3'd0 && !mphase && !drvalid, "R1 reset state", {mstate, mphase}, 16'd0);
    chk(data_rd_n && data_wr_n, "R7 reset strobes idle", {data_rd_n, data_wr_n}, 16'd3);
    rst_n = 1'b1;
  endtask

  initial begin
    void'($urandom(seed));
    // external code, random traffic
    do_reset(1'b0);
    run(2000, 30, 1'b0);
    // directed back-to-back requests held high
    dreq = 1'b1;
    run(200, 100, 1'b0);
    // internal code, select pin toggled after reset (R11)
    do_reset(1'b1);
    run(1500, 25, 1'b1);
    // idle internal: only the address strobe toggles
    run(120, 0, 1'b1);
    // back to external with the pin toggling after reset (R11)
    do_reset(1'b0);
    run(1500, 40, 1'b1);
    checks++;
    if (n_acc < 20 || n_rd < 5) begin
      errors++;
      $display("FAIL R6 too few accesses act=%0d exp>=20 reads act=%0d exp>=5", n_acc, n_rd);
    end
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule